// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the memory-side directory for one slice of a distributed shared memory. It keeps a coherence record for every line of its slice: a state (unused, shared or exclusive), a dirty flag, and a presence vector with one bit per node. The node count is fixed when the block is built. Requests from remote nodes arrive on a request stream and acknowledgements or owner data return on a response stream. The block answers on an outgoing message stream. Coherence traffic goes only to the nodes recorded in the presence vector, so the block never broadcasts.

The block runs one transaction at a time, which also serialises all traffic to any single line. All three ports use valid/ready. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low from that handshake until the transaction finishes, including the wait for invalidation acknowledgements or owner data. Responses are taken only while a transaction is waiting for them. Once a message is offered, it stays on the port with unchanged kind, destination and line until `msg_ready` accepts it.

Request kinds: 0 read, 1 write (ownership request), 2 write-back. Response kinds: 0 acknowledge, 1 acknowledge with line data. Message kinds: 0 exclusive data, 1 shared data, 2 share-downgrade, 3 forwarded read, 4 invalidate, 5 write grant with data.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is unused with stored value zero, `req_ready` is 1 and `msg_valid` is 0.
- R2: A read to an unused line sends kind 0 to the requester with the stored value, and the requester becomes the clean exclusive owner.
- R3: A read by another node to a clean exclusive line sends kind 2 to the owner, then kind 1 with the stored value to the requester, and the line becomes shared by both.
- R4: A read to a shared line sends kind 1 with the stored value to the requester and adds it to the presence vector.
- R5: A read by another node to a dirty exclusive line sends kind 3 to the owner, with the requester in `msg_req`, and sends no data reply from home. A kind 1 response from the owner writes its data to the store, and the line becomes shared by the owner and the requester.
- R6: A write sends one kind 4 message to each recorded sharer other than the writer, lowest node index first, and to no other node.
- R7: The write grant (kind 5, carrying the stored value) is sent only after every invalidated node has answered. A kind 1 answer writes its data to the store. The line then becomes dirty exclusive with the writer as sole owner. A write with no other sharers is granted at once.
- R8: A write-back writes its data to the store, clears the sender's presence bit and sends no message. The line becomes unused when no presence bit remains set, and otherwise stays shared.
- R9: Only one transaction is in flight: after a request handshake `req_ready` stays low until the transaction completes, and `rsp_ready` is never high while `req_ready` is high.
- R10: While `msg_valid` is high and `msg_ready` is low, the message stays valid with unchanged kind, destination and line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when both are high |
| req_kind | input | 2 | 0 read, 1 write, 2 write-back |
| req_src | input | NID_W | Requesting node |
| req_line | input | LINE_W | Line index in this slice |
| req_data | input | DATA_W | Write-back data |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response accepted when both are high |
| rsp_kind | input | 1 | 0 acknowledge, 1 acknowledge with data |
| rsp_src | input | NID_W | Responding node |
| rsp_data | input | DATA_W | Line data carried by kind 1 |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Message accepted when both are high |
| msg_kind | output | 3 | Message kind, 0 to 5 |
| msg_dst | output | NID_W | Destination node |
| msg_req | output | NID_W | Original requester (used by kind 3) |
| msg_line | output | LINE_W | Line index |
| msg_data | output | DATA_W | Line data for kinds 0, 1 and 5 |

## Verification
The bench builds the block with four nodes, four lines and 16-bit data. With four nodes, a single line can hold three sharers plus a writer, so the invalidation ordering and the ack-counting wait are exercised with several targets. The lines are few enough that the bench drives one line through every state change: unused, clean exclusive, shared, dirty exclusive, and back through write-backs. A second line covers ownership passing directly from one dirty owner to another writer.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    LN_UNUSED = 2'd0,
    LN_SHARED = 2'd1,
    LN_EXCL   = 2'd2
  } line_st_t;

  typedef enum logic [2:0] {
    C_IDLE, C_EVAL, C_DOWN, C_FWD, C_WAIT_OWN, C_INV, C_WAIT_ACK, C_REPLY
  } ctl_st_t;

  localparam logic [1:0] REQ_READ  = 2'd0;
  localparam logic [1:0] REQ_WRITE = 2'd1;
  localparam logic [1:0] REQ_WBACK = 2'd2;

  localparam logic RSP_ACK  = 1'b0;
  localparam logic RSP_DATA = 1'b1;

  localparam logic [2:0] MSG_DATA_EXCL  = 3'd0;
  localparam logic [2:0] MSG_DATA_SHR   = 3'd1;
  localparam logic [2:0] MSG_SHARE_DOWN = 3'd2;
  localparam logic [2:0] MSG_FWD_READ   = 3'd3;
  localparam logic [2:0] MSG_INVAL      = 3'd4;
  localparam logic [2:0] MSG_GRANT      = 3'd5;

endpackage

// File: rtl/dir_low_pick.sv
module dir_low_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] mask,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx = W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dir_tag_store.sv
module dir_tag_store
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 16,
  parameter int LINE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINE_W-1:0] raddr,
  output line_st_t         rstate,
  output logic             rdirty,
  output logic [NODES-1:0] rsharers,
  input  logic             we,
  input  logic [LINE_W-1:0] waddr,
  input  line_st_t         wstate,
  input  logic             wdirty,
  input  logic [NODES-1:0] wsharers
);
  line_st_t         st_a    [LINES];
  logic             dirty_a [LINES];
  logic [NODES-1:0] shr_a   [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_a[i]    <= LN_UNUSED;
        dirty_a[i] <= 1'b0;
        shr_a[i]   <= '0;
      end
    end else if (we) begin
      st_a[waddr]    <= wstate;
      dirty_a[waddr] <= wdirty;
      shr_a[waddr]   <= wsharers;
    end
  end

  assign rstate   = st_a[raddr];
  assign rdirty   = dirty_a[raddr];
  assign rsharers = shr_a[raddr];
endmodule

// File: rtl/dir_line_store.sv
module dir_line_store #(
  parameter int LINES  = 16,
  parameter int LINE_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] addr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] mem_a [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem_a[i] <= '0;
    end else if (we) begin
      mem_a[addr] <= wdata;
    end
  end

  assign rdata = mem_a[addr];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int NID_W  = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [NID_W-1:0]  req_src,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_kind,
  input  logic [NID_W-1:0]  rsp_src,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [2:0]        msg_kind,
  output logic [NID_W-1:0]  msg_dst,
  output logic [NID_W-1:0]  msg_req,
  output logic [LINE_W-1:0] msg_line,
  output logic [DATA_W-1:0] msg_data
);
  ctl_st_t            st_q, st_d;
  logic [1:0]         kind_q;
  logic [NID_W-1:0]   src_q, owner_q, owner_d;
  logic [LINE_W-1:0]  line_q;
  logic [DATA_W-1:0]  data_q;
  logic [NODES-1:0]   pend_q, pend_d, wait_q, wait_d;
  logic [2:0]         rkind_q, rkind_d;

  line_st_t           rd_state, wr_state;
  logic               rd_dirty, wr_dirty, tag_we;
  logic [NODES-1:0]   rd_shr, wr_shr;
  logic [DATA_W-1:0]  rd_data, dt_wdata;
  logic               dt_we;

  logic [NODES-1:0]   src_oh, others, rsp_oh;
  logic [NID_W-1:0]   own_idx, inv_idx;
  logic               own_any, inv_any, oth_any;

  logic req_fire, rsp_fire, msg_fire;

  assign req_fire = req_valid && req_ready;
  assign rsp_fire = rsp_valid && rsp_ready;
  assign msg_fire = msg_valid && msg_ready;

  always_comb begin
    src_oh = '0;
    src_oh[src_q] = 1'b1;
    rsp_oh = '0;
    rsp_oh[rsp_src] = 1'b1;
  end
  assign others = rd_shr & ~src_oh;

  dir_tag_store #(.NODES(NODES), .LINES(LINES), .LINE_W(LINE_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .raddr(line_q),
    .rstate(rd_state), .rdirty(rd_dirty), .rsharers(rd_shr),
    .we(tag_we), .waddr(line_q), .wstate(wr_state), .wdirty(wr_dirty), .wsharers(wr_shr)
  );

  dir_line_store #(.LINES(LINES), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .addr(line_q), .rdata(rd_data),
    .we(dt_we), .wdata(dt_wdata)
  );

  dir_low_pick #(.N(NODES), .W(NID_W)) u_own_pick (
    .mask(rd_shr), .idx(own_idx), .any(own_any)
  );

  dir_low_pick #(.N(NODES), .W(NID_W)) u_inv_pick (
    .mask(pend_q), .idx(inv_idx), .any(inv_any)
  );

  assign oth_any = |others;

  // Port handshake controls
  assign req_ready = (st_q == C_IDLE);
  assign rsp_ready = (st_q == C_INV) || (st_q == C_WAIT_ACK) || (st_q == C_WAIT_OWN);

  always_comb begin
    msg_valid = 1'b0;
    msg_kind  = rkind_q;
    msg_dst   = src_q;
    unique case (st_q)
      C_DOWN:  begin msg_valid = 1'b1; msg_kind = MSG_SHARE_DOWN; msg_dst = owner_q; end
      C_FWD:   begin msg_valid = 1'b1; msg_kind = MSG_FWD_READ;   msg_dst = owner_q; end
      C_INV:   begin msg_valid = inv_any; msg_kind = MSG_INVAL;   msg_dst = inv_idx; end
      C_REPLY: begin msg_valid = 1'b1; end
      default: ;
    endcase
  end
  assign msg_req  = src_q;
  assign msg_line = line_q;
  assign msg_data = rd_data;

  // Transaction sequencing and directory updates
  always_comb begin
    st_d     = st_q;
    owner_d  = owner_q;
    pend_d   = pend_q;
    wait_d   = wait_q;
    rkind_d  = rkind_q;
    tag_we   = 1'b0;
    wr_state = rd_state;
    wr_dirty = rd_dirty;
    wr_shr   = rd_shr;
    dt_we    = 1'b0;
    dt_wdata = rsp_data;

    unique case (st_q)
      C_IDLE: if (req_fire) st_d = C_EVAL;

      C_EVAL: begin
        if (kind_q == REQ_READ) begin
          unique case (rd_state)
            LN_UNUSED: begin
              tag_we = 1'b1; wr_state = LN_EXCL; wr_dirty = 1'b0; wr_shr = src_oh;
              rkind_d = MSG_DATA_EXCL; st_d = C_REPLY;
            end
            LN_SHARED: begin
              tag_we = 1'b1; wr_shr = rd_shr | src_oh;
              rkind_d = MSG_DATA_SHR; st_d = C_REPLY;
            end
            default: begin
              if (!own_any || own_idx == src_q) begin
                rkind_d = MSG_DATA_EXCL; st_d = C_REPLY;
              end else begin
                tag_we = 1'b1; wr_state = LN_SHARED; wr_dirty = 1'b0;
                wr_shr = rd_shr | src_oh;
                owner_d = own_idx;
                rkind_d = MSG_DATA_SHR;
                st_d = rd_dirty ? C_FWD : C_DOWN;
              end
            end
          endcase
        end else if (kind_q == REQ_WRITE) begin
          tag_we = 1'b1; wr_state = LN_EXCL; wr_dirty = 1'b1; wr_shr = src_oh;
          pend_d = others;
          wait_d = others;
          rkind_d = MSG_GRANT;
          st_d = oth_any ? C_INV : C_REPLY;
        end else begin
          dt_we = 1'b1; dt_wdata = data_q;
          tag_we = 1'b1; wr_dirty = 1'b0; wr_shr = others;
          wr_state = oth_any ? LN_SHARED : LN_UNUSED;
          st_d = C_IDLE;
        end
      end

      C_DOWN: if (msg_fire) st_d = C_REPLY;

      C_FWD:  if (msg_fire) st_d = C_WAIT_OWN;

      C_WAIT_OWN: begin
        if (rsp_fire && rsp_src == owner_q) begin
          dt_we = (rsp_kind == RSP_DATA);
          st_d  = C_IDLE;
        end
      end

      C_INV, C_WAIT_ACK: begin
        if (rsp_fire && (wait_q & rsp_oh) != '0) begin
          wait_d = wait_q & ~rsp_oh;
          dt_we  = (rsp_kind == RSP_DATA);
        end
        if (st_q == C_INV) begin
          if (msg_fire) pend_d = pend_q & ~(NODES'(1) << inv_idx);
          if (pend_d == '0) st_d = C_WAIT_ACK;
        end else if (wait_q == '0) begin
          st_d = C_REPLY;
        end
      end

      C_REPLY: if (msg_fire) st_d = C_IDLE;

      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= C_IDLE;
      kind_q  <= REQ_READ;
      src_q   <= '0;
      owner_q <= '0;
      line_q  <= '0;
      data_q  <= '0;
      pend_q  <= '0;
      wait_q  <= '0;
      rkind_q <= MSG_DATA_EXCL;
    end else begin
      st_q    <= st_d;
      owner_q <= owner_d;
      pend_q  <= pend_d;
      wait_q  <= wait_d;
      rkind_q <= rkind_d;
      if (req_fire) begin
        kind_q <= req_kind;
        src_q  <= req_src;
        line_q <= req_line;
        data_q <= req_data;
      end
    end
  end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk
  import dir_pkg::*;
#(
  parameter int NID_W  = 2,
  parameter int LINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [NID_W-1:0]  req_src,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [2:0]        msg_kind,
  input logic [NID_W-1:0]  msg_dst,
  input logic [LINE_W-1:0] msg_line
);
  logic [NID_W:0]   inv_open;
  logic [NID_W-1:0] writer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_open <= '0;
      writer_q <= '0;
    end else begin
      if (req_valid && req_ready) writer_q <= req_src;
      if (msg_valid && msg_ready && msg_kind == MSG_INVAL)
        inv_open <= inv_open + 1'b1;
      else if (rsp_valid && rsp_ready && inv_open != '0)
        inv_open <= inv_open - 1'b1;
    end
  end

  p_msg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_dst) && $stable(msg_line));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_rsp_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_ready);

  p_grant_after_acks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MSG_GRANT |-> inv_open == '0);

  p_inv_not_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MSG_INVAL |-> msg_dst != writer_q);

  p_wb_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind == REQ_WBACK |=> !msg_valid ##1 !msg_valid);
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NID_W(NID_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_src(req_src),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
  .msg_dst(msg_dst), .msg_line(msg_line)
);

// File: tb/dir_home_ctrl_tb_top.sv
module dir_home_ctrl_tb_top;
  localparam int NODES = 4;
  localparam int LINES = 4;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0;
  logic [1:0] req_src = '0;
  logic [1:0] req_line = '0;
  logic [DW-1:0] req_data = '0;
  logic rsp_valid = 1'b0, rsp_ready;
  logic rsp_kind = 1'b0;
  logic [1:0] rsp_src = '0;
  logic [DW-1:0] rsp_data = '0;
  logic msg_valid, msg_ready = 1'b0;
  logic [2:0] msg_kind;
  logic [1:0] msg_dst, msg_req, msg_line;
  logic [DW-1:0] msg_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .LINES(LINES), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_src(req_src), .req_line(req_line), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_src(rsp_src), .rsp_data(rsp_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_dst(msg_dst), .msg_req(msg_req), .msg_line(msg_line), .msg_data(msg_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_req(input logic [1:0] k, input int src, input int line, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = src[1:0];
    req_line = line[1:0]; req_data = d[DW-1:0];
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic send_rsp(input logic k, input int src, input int d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_kind = k; rsp_src = src[1:0]; rsp_data = d[DW-1:0];
    while (!rsp_ready) @(negedge clk);
    @(posedge clk); #1 rsp_valid = 1'b0;
  endtask

  // Waits for one message, compares it and accepts it.
  task automatic expect_msg(input int k, input int dst, input int d, input int rq, input string tag);
    int n = 0;
    @(negedge clk);
    while (!msg_valid && n < 40) begin @(negedge clk); n++; end
    if (!msg_valid) begin
      chk(1'b0, {tag, " no message"}, 0, 1);
    end else begin
      chk(msg_kind == 3'(k), {tag, " kind"}, int'(msg_kind), k);
      chk(msg_dst == 2'(dst), {tag, " dst"}, int'(msg_dst), dst);
      if (d >= 0) chk(msg_data == DW'(d), {tag, " data"}, int'(msg_data), d);
      if (rq >= 0) chk(msg_req == 2'(rq), {tag, " req"}, int'(msg_req), rq);
      msg_ready = 1'b1;
      @(posedge clk); #1 msg_ready = 1'b0;
    end
  endtask

  task automatic expect_quiet(input int cycles, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(!seen, tag, int'(seen), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    chk(msg_valid == 1'b0, "R1 msg_valid after reset", int'(msg_valid), 0);
  endtask

  task automatic t_read_unused();
    send_req(2'd0, 1, 0, 0);
    expect_msg(0, 1, 'h0000, -1, "R2 R1 read unused line zero");
    send_req(2'd2, 1, 0, 'h1234);
    expect_quiet(4, "R8 write-back sends nothing");
    send_req(2'd0, 2, 0, 0);
    expect_msg(0, 2, 'h1234, -1, "R8 R2 line unused after write-back");
  endtask

  task automatic t_clean_excl();
    send_req(2'd0, 3, 0, 0);
    repeat (4) @(negedge clk);
    chk(msg_valid && msg_kind == 3'd2, "R10 message held without ready", int'(msg_kind), 2);
    expect_msg(2, 2, -1, -1, "R3 share-downgrade to owner");
    expect_msg(1, 3, 'h1234, -1, "R3 shared data to reader");
  endtask

  task automatic t_shared_read();
    send_req(2'd0, 0, 0, 0);
    expect_msg(1, 0, 'h1234, -1, "R4 shared read");
  endtask

  task automatic t_write_inval();
    send_req(2'd1, 0, 0, 0);
    expect_msg(4, 2, -1, -1, "R6 invalidate lowest sharer");
    expect_msg(4, 3, -1, -1, "R6 invalidate next sharer");
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 request stalled during write", int'(req_ready), 0);
    send_rsp(1'b0, 2, 0);
    expect_quiet(4, "R7 no grant before last ack");
    send_rsp(1'b0, 3, 0);
    expect_msg(5, 0, 'h1234, -1, "R7 grant after all acks");
  endtask

  task automatic t_dirty_read();
    send_req(2'd0, 1, 0, 0);
    expect_msg(3, 0, -1, 1, "R5 forwarded read to dirty owner");
    expect_quiet(4, "R5 no data reply from home");
    send_rsp(1'b1, 0, 'hBEEF);
    send_req(2'd0, 2, 0, 0);
    expect_msg(1, 2, 'hBEEF, -1, "R5 owner data stored, line shared");
  endtask

  task automatic t_write_dirty_owner();
    send_req(2'd1, 3, 1, 0);
    expect_msg(5, 3, 'h0000, -1, "R7 immediate grant on unused line");
    send_req(2'd1, 1, 1, 0);
    expect_msg(4, 3, -1, -1, "R6 invalidate dirty owner");
    send_rsp(1'b1, 3, 'h5555);
    expect_msg(5, 1, 'h5555, -1, "R7 grant carries owner data");
  endtask

  task automatic t_wb_owner();
    send_req(2'd2, 1, 1, 'h7777);
    send_req(2'd0, 0, 1, 0);
    expect_msg(0, 0, 'h7777, -1, "R8 owner write-back frees line");
  endtask

  task automatic t_wb_sharer();
    send_req(2'd2, 2, 0, 'h4444);
    send_req(2'd0, 3, 0, 0);
    expect_msg(1, 3, 'h4444, -1, "R8 sharer write-back keeps line shared");
    send_req(2'd1, 3, 0, 0);
    expect_msg(4, 0, -1, -1, "R6 R8 invalidate node 0");
    expect_msg(4, 1, -1, -1, "R6 R8 invalidate node 1, not node 2");
    send_rsp(1'b0, 0, 0);
    send_rsp(1'b0, 1, 0);
    expect_msg(5, 3, 'h4444, -1, "R7 grant to writer");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_read_unused();
    t_clean_excl();
    t_shared_read();
    t_write_inval();
    t_dirty_read();
    t_write_dirty_owner();
    t_wb_owner();
    t_wb_sharer();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule